// File: doc/BRIEF.md
# Serial-Loaded Memory Bank Controller

This block sits on the cartridge side of a small console bus. It turns narrow CPU and video addresses into wide physical addresses for program ROM, pattern memory and nametable RAM. Software configures it one bit per CPU write. Each write feeds bit 0 of the data byte into a five-bit serial register. The fifth write commits the assembled value to one of four configuration registers, and address bits 14:13 of that write select which one. A write with bit 7 set aborts any partial load and forces a safe program layout. After every accepted write, further writes are locked out for a short time.

The CPU write port is a valid/ready stream. `wr_ready` is high exactly when the lockout has expired. A beat with `wr_valid` high while `wr_ready` is low is dropped: it is not held, queued or retried, so the sender must keep the beat until it sees `wr_ready`. All three translations are combinational from the current configuration and the presented address. A configuration change shows on the translated outputs in the cycle after the committing clock edge.

Top module: `serial_bank_ctrl`

## Requirements
- R1: An accepted write (`wr_valid` and `wr_ready`) drops `wr_ready` for exactly two cycles. Beats offered in those cycles change nothing, and the beat on the third following edge is accepted again.
- R2: An accepted write with data bit 7 set clears the serial bit count and sets program-size to 16 KB and program-fixed-high to 1. It commits no register, and the serial bits gathered so far are discarded.
- R3: Any other accepted write shifts data bit 0 into the top (bit 4) of the serial register, so the first write supplies bit 0 of the committed value. The fifth such write commits the value and restarts the count.
- R4: The address bits 14:13 of the committing write pick the target: 0 control, 1 pattern bank A, 2 pattern bank B, 3 program register.
- R5: Control value layout: bit 4 pattern-split, bit 3 program-size (1 = 16 KB windows, 0 = 32 KB), bit 2 program-fixed-high, bits 1:0 mirroring. Program value layout: bit 4 work-RAM disable, bits 3:0 program bank.
- R6: In 32 KB mode, `prg_out` = ({bank[3:1], prg_in[14]} << 14) | prg_in[13:0].
- R7: In 16 KB mode, the 16 KB half (prg_in[14]) that differs from program-fixed-high uses the program bank. The other half is fixed: bank 0 for the lower half, bank 15 for the upper half.
- R8: With pattern-split 1, `chr_in[12]` selects bank A (0) or bank B (1). With split 0, the bank is bank A with bit 0 replaced by `chr_in[12]`. `chr_out` = (bank << 12) | chr_in[11:0].
- R9: `nt_out[9:0]` = `nt_in[9:0]`. Bit 10 depends on mirroring: mode 0 gives 0, mode 1 gives 1, mode 2 copies `nt_in[10]`, and mode 3 copies `nt_in[11]`.
- R10: After reset: `wr_ready` high, serial state empty, pattern-split 0, mirroring 0, bank A 0, bank B 1, program bank 0, work-RAM disable 0, 16 KB mode with the upper half fixed.
- R11: `wram_disable` equals bit 4 of the last committed program value (active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | CPU write beat offered |
| wr_ready | output | 1 | Lockout expired; a beat is taken this cycle |
| wr_addr | input | 15 | CPU write address; bits 14:13 pick the target register |
| wr_data | input | 8 | CPU write data; bit 7 aborts, bit 0 is the serial bit |
| prg_in | input | 15 | CPU program-space address |
| prg_out | output | 18 | Translated program ROM address |
| chr_in | input | 13 | Video pattern-space address |
| chr_out | output | 17 | Translated pattern memory address |
| nt_in | input | 12 | Video nametable-space address |
| nt_out | output | 11 | Translated nametable RAM address |
| wram_disable | output | 1 | Work-RAM disable flag, active high |

## Verification
The assertions assume that reset is held for at least one edge before any beat is offered. They also assume that the translation inputs are stable around each sampling edge. The bench drives every input on the falling edge, so each input is settled before the rising edge. Besides full five-beat loads, the bench offers beats on purpose during the lockout and abandons a load part-way with the abort bit. This exercises dropped beats and reset-bit recovery, which the assertions check as their state properties.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int DATA_W      = 8;
  localparam int CPU_AW      = 15;
  localparam int SHIFT_W     = 5;
  localparam int LOCK_CYCLES = 2;
  localparam int PRG_OFS_W   = 14;
  localparam int PRG_BANK_W  = 4;
  localparam int CHR_OFS_W   = 12;
  localparam int CHR_BANK_W  = 5;
  localparam int NT_OFS_W    = 10;

  localparam int PRG_OUT_W = PRG_OFS_W + PRG_BANK_W;
  localparam int CHR_IN_W  = CHR_OFS_W + 1;
  localparam int CHR_OUT_W = CHR_OFS_W + CHR_BANK_W;
  localparam int NT_IN_W   = NT_OFS_W + 2;
  localparam int NT_OUT_W  = NT_OFS_W + 1;
  localparam int CNT_W     = $clog2(SHIFT_W);
  localparam int LOCK_W    = $clog2(LOCK_CYCLES + 1);

  typedef enum logic [1:0] {
    MIR_LOW  = 2'd0,
    MIR_HIGH = 2'd1,
    MIR_A10  = 2'd2,
    MIR_A11  = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    DST_CTRL = 2'd0,
    DST_CHRA = 2'd1,
    DST_CHRB = 2'd2,
    DST_PRG  = 2'd3
  } dest_e;

  typedef struct packed {
    logic                  chr_split;
    logic                  prg_16k;
    logic                  fix_hi;
    mirror_e               mirror;
    logic [CHR_BANK_W-1:0] chr_a;
    logic [CHR_BANK_W-1:0] chr_b;
    logic                  wram_off;
    logic [PRG_BANK_W-1:0] prg_bank;
  } cfg_t;
endpackage

// File: rtl/sbc_write_guard.sv
module sbc_write_guard #(
  parameter int LOCK_CYCLES = sbc_pkg::LOCK_CYCLES,
  localparam int LW = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  output logic wr_ready,
  output logic wr_accept
);
  logic [LW-1:0] lock_cnt;

  assign wr_ready  = (lock_cnt == '0);
  assign wr_accept = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst)               lock_cnt <= '0;
    else if (wr_accept)    lock_cnt <= LW'(LOCK_CYCLES);
    else if (!wr_ready)    lock_cnt <= lock_cnt - 1'b1;
  end
endmodule

// File: rtl/sbc_serial_loader.sv
module sbc_serial_loader
  import sbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_accept,
  input  logic             wr_abort,
  input  logic             wr_bit,
  input  dest_e            wr_dest,
  output cfg_t             cfg,
  output logic [CNT_W-1:0] sh_cnt
);
  logic [SHIFT_W-1:0] sh_data;
  logic [SHIFT_W-1:0] sh_next;
  logic               last_beat;

  assign sh_next   = {wr_bit, sh_data[SHIFT_W-1:1]};
  assign last_beat = (sh_cnt == CNT_W'(SHIFT_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cnt        <= '0;
      sh_data       <= '0;
      cfg.chr_split <= 1'b0;
      cfg.prg_16k   <= 1'b1;
      cfg.fix_hi    <= 1'b1;
      cfg.mirror    <= MIR_LOW;
      cfg.chr_a     <= '0;
      cfg.chr_b     <= CHR_BANK_W'(1);
      cfg.wram_off  <= 1'b0;
      cfg.prg_bank  <= '0;
    end else if (wr_accept) begin
      if (wr_abort) begin
        sh_cnt      <= '0;
        cfg.prg_16k <= 1'b1;
        cfg.fix_hi  <= 1'b1;
      end else begin
        sh_data <= sh_next;
        if (!last_beat) begin
          sh_cnt <= sh_cnt + 1'b1;
        end else begin
          sh_cnt <= '0;
          unique case (wr_dest)
            DST_CTRL: begin
              cfg.chr_split <= sh_next[4];
              cfg.prg_16k   <= sh_next[3];
              cfg.fix_hi    <= sh_next[2];
              cfg.mirror    <= mirror_e'(sh_next[1:0]);
            end
            DST_CHRA: cfg.chr_a <= sh_next[CHR_BANK_W-1:0];
            DST_CHRB: cfg.chr_b <= sh_next[CHR_BANK_W-1:0];
            DST_PRG: begin
              cfg.wram_off <= sh_next[4];
              cfg.prg_bank <= sh_next[PRG_BANK_W-1:0];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sbc_addr_map.sv
module sbc_addr_map
  import sbc_pkg::*;
(
  input  cfg_t                 cfg,
  input  logic [CPU_AW-1:0]    prg_in,
  output logic [PRG_OUT_W-1:0] prg_out,
  input  logic [CHR_IN_W-1:0]  chr_in,
  output logic [CHR_OUT_W-1:0] chr_out,
  input  logic [NT_IN_W-1:0]   nt_in,
  output logic [NT_OUT_W-1:0]  nt_out
);
  logic                  prg_half;
  logic [PRG_BANK_W-1:0] prg_sel;
  logic                  chr_half;
  logic [CHR_BANK_W-1:0] chr_sel;
  logic                  nt_page;

  assign prg_half = prg_in[PRG_OFS_W];
  assign chr_half = chr_in[CHR_OFS_W];

  always_comb begin
    if (!cfg.prg_16k)
      prg_sel = {cfg.prg_bank[PRG_BANK_W-1:1], prg_half};
    else if (prg_half != cfg.fix_hi)
      prg_sel = cfg.prg_bank;
    else
      prg_sel = {PRG_BANK_W{prg_half}};
  end

  always_comb begin
    if (cfg.chr_split)
      chr_sel = chr_half ? cfg.chr_b : cfg.chr_a;
    else
      chr_sel = {cfg.chr_a[CHR_BANK_W-1:1], chr_half};
  end

  always_comb begin
    unique case (cfg.mirror)
      MIR_LOW:  nt_page = 1'b0;
      MIR_HIGH: nt_page = 1'b1;
      MIR_A10:  nt_page = nt_in[NT_OFS_W];
      MIR_A11:  nt_page = nt_in[NT_OFS_W+1];
      default:  nt_page = 1'b0;
    endcase
  end

  assign prg_out = {prg_sel, prg_in[PRG_OFS_W-1:0]};
  assign chr_out = {chr_sel, chr_in[CHR_OFS_W-1:0]};
  assign nt_out  = {nt_page, nt_in[NT_OFS_W-1:0]};
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import sbc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [CPU_AW-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CPU_AW-1:0]    prg_in,
  output logic [PRG_OUT_W-1:0] prg_out,
  input  logic [CHR_IN_W-1:0]  chr_in,
  output logic [CHR_OUT_W-1:0] chr_out,
  input  logic [NT_IN_W-1:0]   nt_in,
  output logic [NT_OUT_W-1:0]  nt_out,
  output logic                 wram_disable
);
  logic             wr_accept;
  cfg_t             cfg;
  logic [CNT_W-1:0] sh_cnt;
  logic             pins_unused;

  assign pins_unused = ^{wr_addr[CPU_AW-3:0], wr_data[DATA_W-2:1]};

  sbc_write_guard #(.LOCK_CYCLES(LOCK_CYCLES)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_accept (wr_accept)
  );

  sbc_serial_loader u_loader (
    .clk       (clk),
    .rst       (rst),
    .wr_accept (wr_accept),
    .wr_abort  (wr_data[DATA_W-1]),
    .wr_bit    (wr_data[0]),
    .wr_dest   (dest_e'(wr_addr[CPU_AW-1:CPU_AW-2])),
    .cfg       (cfg),
    .sh_cnt    (sh_cnt)
  );

  sbc_addr_map u_map (
    .cfg     (cfg),
    .prg_in  (prg_in),
    .prg_out (prg_out),
    .chr_in  (chr_in),
    .chr_out (chr_out),
    .nt_in   (nt_in),
    .nt_out  (nt_out)
  );

  assign wram_disable = cfg.wram_off;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
  import sbc_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_valid,
  input logic                 wr_ready,
  input logic [DATA_W-1:0]    wr_data,
  input logic [CPU_AW-1:0]    prg_in,
  input logic [PRG_OUT_W-1:0] prg_out,
  input logic [CHR_IN_W-1:0]  chr_in,
  input logic [CHR_OUT_W-1:0] chr_out,
  input logic [NT_IN_W-1:0]   nt_in,
  input logic [NT_OUT_W-1:0]  nt_out,
  input cfg_t                 cfg,
  input logic [CNT_W-1:0]     sh_cnt
);
  assert_lock_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  assert_locked_holds_state_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |=> ($stable(sh_cnt) && $stable(cfg)));

  assert_abort_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_data[DATA_W-1]) |=>
      (sh_cnt == '0 && cfg.prg_16k && cfg.fix_hi));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    sh_cnt < CNT_W'(SHIFT_W));

  assert_prg_32k_half_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg.prg_16k |-> (prg_out[PRG_OFS_W] == prg_in[PRG_OFS_W] &&
                      prg_out[PRG_OFS_W-1:0] == prg_in[PRG_OFS_W-1:0]));

  assert_prg_fixed_top_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg.prg_16k && cfg.fix_hi && prg_in[PRG_OFS_W]) |->
      (prg_out[PRG_OUT_W-1:PRG_OFS_W] == '1));

  assert_chr_offset_R8: assert property (@(posedge clk) disable iff (rst)
    chr_out[CHR_OFS_W-1:0] == chr_in[CHR_OFS_W-1:0] &&
    (cfg.chr_split || chr_out[CHR_OFS_W] == chr_in[CHR_OFS_W]));

  assert_nt_offset_R9: assert property (@(posedge clk) disable iff (rst)
    nt_out[NT_OFS_W-1:0] == nt_in[NT_OFS_W-1:0]);
endmodule

bind serial_bank_ctrl sbc_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .prg_in   (prg_in),
  .prg_out  (prg_out),
  .chr_in   (chr_in),
  .chr_out  (chr_out),
  .nt_in    (nt_in),
  .nt_out   (nt_out),
  .cfg      (cfg),
  .sh_cnt   (sh_cnt)
);

// File: tb/serial_bank_ctrl_tb.sv
module serial_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] prg_in = '0;
  logic [17:0] prg_out;
  logic [12:0] chr_in = '0;
  logic [16:0] chr_out;
  logic [11:0] nt_in = '0;
  logic [10:0] nt_out;
  logic        wram_disable;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prg_in(prg_in), .prg_out(prg_out),
    .chr_in(chr_in), .chr_out(chr_out), .nt_in(nt_in), .nt_out(nt_out),
    .wram_disable(wram_disable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one accepted beat, then wait out the lockout
  task automatic put(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] dst, input logic [4:0] v);
    for (int i = 0; i < 5; i++) put({dst, 13'h0}, {7'h0, v[i]});
  endtask

  task automatic look_prg(input string req, input logic [14:0] a, input logic [17:0] e);
    prg_in = a; #1; chk(req, 32'(prg_out), 32'(e));
  endtask
  task automatic look_chr(input string req, input logic [12:0] a, input logic [16:0] e);
    chr_in = a; #1; chk(req, 32'(chr_out), 32'(e));
  endtask
  task automatic look_nt(input string req, input logic [11:0] a, input logic [10:0] e);
    nt_in = a; #1; chk(req, 32'(nt_out), 32'(e));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 ready", 32'(wr_ready), 32'd1);
    chk("R10 wram", 32'(wram_disable), 32'd0);
    look_prg("R10 prg low half", 15'h0123, 18'h00123);
    look_prg("R10 prg top fixed", 15'h4123, 18'h3C123);
    look_chr("R10 chr unsplit", 13'h1abc, 17'h01abc);
    look_nt("R10 mirror 0", 12'hfff, 11'h3ff);
    load(2'd0, 5'b10000);
    look_chr("R10 bank A zero", 13'h0abc, 17'h00abc);
    look_chr("R10 bank B one", 13'h1abc, 17'h01abc);
  endtask

  task automatic t_lockout;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 15'h0; wr_data = 8'h01;
    @(negedge clk);
    chk("R1 ready low 1", 32'(wr_ready), 32'd0);
    wr_data = 8'h80;
    @(negedge clk);
    chk("R1 ready low 2", 32'(wr_ready), 32'd0);
    @(negedge clk);
    chk("R1 ready back", 32'(wr_ready), 32'd1);
    wr_valid = 1'b0;
    for (int i = 0; i < 4; i++) put(15'h0, 8'h00);
    look_nt("R1 dropped abort, R3 bit order", 12'h000, 11'h400);
  endtask

  task automatic t_abort;
    put(15'h0, 8'h80);
    look_prg("R2 forced 16K lower", 15'h0000, 18'h00000);
    look_prg("R2 forced 16K upper", 15'h4000, 18'h3C000);
    put(15'h2000, 8'h01);
    put(15'h2000, 8'h01);
    put(15'h2000, 8'h80);
    load(2'd1, 5'b00110);
    look_chr("R2 partial discarded", 13'h0000, 17'h06000);
    look_chr("R2 R8 unsplit odd", 13'h1000, 17'h07000);
  endtask

  task automatic t_prg32;
    load(2'd0, 5'b00000);
    load(2'd3, 5'b10101);
    chk("R11 wram set", 32'(wram_disable), 32'd1);
    look_prg("R6 32K low", 15'h0010, 18'h10010);
    look_prg("R6 32K high", 15'h7fff, 18'h17fff);
    load(2'd3, 5'b00101);
    chk("R11 wram clear", 32'(wram_disable), 32'd0);
  endtask

  task automatic t_prg16;
    load(2'd0, 5'b01100);
    look_prg("R7 fixhi low", 15'h0010, 18'h14010);
    look_prg("R7 fixhi high", 15'h4010, 18'h3C010);
    load(2'd0, 5'b01000);
    look_prg("R7 fixlo low", 15'h0010, 18'h00010);
    look_prg("R7 fixlo high", 15'h4010, 18'h14010);
  endtask

  task automatic t_chr;
    load(2'd0, 5'b10000);
    load(2'd1, 5'h13);
    load(2'd2, 5'h0a);
    look_chr("R8 R4 split A", 13'h0456, 17'h13456);
    look_chr("R8 R4 split B", 13'h1456, 17'h0a456);
    load(2'd0, 5'b00000);
    look_chr("R8 unsplit even", 13'h0456, 17'h12456);
    look_chr("R8 unsplit odd", 13'h1456, 17'h13456);
  endtask

  task automatic t_mirror;
    load(2'd0, 5'b00000);
    look_nt("R9 R5 mode0 a", 12'h555, 11'h155);
    look_nt("R9 R5 mode0 b", 12'ha55, 11'h255);
    load(2'd0, 5'b00001);
    look_nt("R9 R5 mode1", 12'h155, 11'h555);
    load(2'd0, 5'b00010);
    look_nt("R9 R5 mode2 a", 12'h555, 11'h555);
    look_nt("R9 R5 mode2 b", 12'ha55, 11'h255);
    load(2'd0, 5'b00011);
    look_nt("R9 R5 mode3 a", 12'h555, 11'h155);
    look_nt("R9 R5 mode3 b", 12'ha55, 11'h655);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lockout();
    t_abort();
    t_prg32();
    t_prg16();
    t_chr();
    t_mirror();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule